// File: doc/BRIEF.md
# Predicated Execution Condition Unit

This block sits beside the datapath of a small processor and decides, instruction by instruction, whether the current instruction may take effect. It keeps two status bits, carry and zero, which the datapath reloads after an instruction that is allowed to run. Every instruction carries a three-bit predicate field. The unit combines that field with the stored flags to produce an execute-enable. That enable gates the register-file write strobe and the flag reload.

Two of the field bits are selects with negative logic: a 0 makes the condition depend on its flag, and a 1 masks that flag out. The third bit inverts the result. Of the eight codes, one would mean "never run". That code is reclaimed: an instruction carrying it always runs, and it raises an extra opcode bit, which selects a second bank of operations. The widened opcode leaves the unit with that bit as its most significant bit.

Top module: `pred_cond_unit`

## Requirements
- R1: An active-low asynchronous reset clears both stored flags (`flag_c`, `flag_z`) to 0.
- R2: The predicate field `pred_code` is laid out as bit 2 = invert, bit 1 = carry-select, bit 0 = zero-select. For every code except 3'b111, `exec_en` = invert XOR ((carry-select OR C) AND (zero-select OR Z)), where C and Z are the stored flags.
- R3: The codes map to these conditions: 3'b000 C AND Z; 3'b001 C; 3'b010 Z; 3'b011 always; 3'b100 NOT(C AND Z); 3'b101 NOT C; 3'b110 NOT Z.
- R4: Code 3'b111 raises `opcode_ext` and forces `exec_en` to 1, whatever the flags hold.
- R5: `opcode_ext` is 0 for every code other than 3'b111.
- R6: `op_out` equals `{opcode_ext, op_in}`, so the reclaimed code selects the upper half of the widened opcode space.
- R7: `reg_we_out` is 1 only when both `reg_we_in` and `exec_en` are 1.
- R8: On a rising clock edge with `flag_we` and `exec_en` both 1, `flag_c` takes `c_in` and `flag_z` takes `z_in`. This includes instructions that carry code 3'b111.
- R9: When `exec_en` is 0, a `flag_we` pulse is ignored and both flags keep their values.
- R10: `exec_en` depends only on the flags stored before the current instruction: changing `c_in` or `z_in` within a cycle does not alter `exec_en` in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pred_code | input | 3 | Predicate field of the current instruction |
| op_in | input | OP_W | Base opcode field of the current instruction |
| reg_we_in | input | 1 | Destination write request from the datapath |
| flag_we | input | 1 | Flag reload request from the datapath |
| c_in | input | 1 | New carry value from the ALU |
| z_in | input | 1 | New zero value from the ALU |
| exec_en | output | 1 | Instruction is allowed to take effect |
| opcode_ext | output | 1 | Reclaimed predicate code is present |
| op_out | output | OP_W+1 | Widened opcode with the extension bit on top |
| reg_we_out | output | 1 | Gated destination write strobe |
| flag_c | output | 1 | Stored carry flag |
| flag_z | output | 1 | Stored zero flag |

## Verification
The properties assume that `pred_code`, `flag_we` and the ALU flag inputs are settled and known at each rising edge, and that the datapath presents one instruction per cycle. The bench drives every input on the falling edge and holds it across the next rising edge. It loads flag values with the always-run code and then holds `flag_we` low while it sweeps the predicate codes. As a result, the flag-hold and flag-reload properties see only clean, well-separated events.

// File: rtl/pcu_pkg.sv
package pcu_pkg;

  localparam int PRED_W = 3;
  localparam int FLAG_N = 2;
  localparam int FLAG_C_IDX = 0;
  localparam int FLAG_Z_IDX = 1;

  // Field order is behaviour: bit 2 inverts, bit 1 masks carry, bit 0 masks zero.
  typedef struct packed {
    logic inv;
    logic c_mask;
    logic z_mask;
  } pred_t;

  localparam logic [PRED_W-1:0] RECLAIMED_CODE = 3'b111;

endpackage

// File: rtl/pcu_pred_eval.sv
module pcu_pred_eval
  import pcu_pkg::*;
(
  input  pred_t code,
  input  logic  cur_c,
  input  logic  cur_z,
  output logic  run,
  output logic  ext
);

  logic carry_term;
  logic zero_term;
  logic raw_cond;

  always_comb begin
    carry_term = code.c_mask | cur_c;
    zero_term  = code.z_mask | cur_z;
    raw_cond   = code.inv ^ (carry_term & zero_term);
    ext        = (code == RECLAIMED_CODE);
    run        = raw_cond | ext;
  end

endmodule

// File: rtl/pcu_flag_bank.sv
module pcu_flag_bank #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_en,
  input  logic [N-1:0] d,
  output logic [N-1:0] q
);

  logic [N-1:0] q_r;
  logic [N-1:0] q_nxt;

  for (genvar i = 0; i < N; i++) begin : g_bit
    always_comb begin
      q_nxt[i] = q_r[i];
      if (load_en) q_nxt[i] = d[i];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q_r[i] <= 1'b0;
      else        q_r[i] <= q_nxt[i];
    end
  end

  assign q = q_r;

endmodule

// File: rtl/pred_cond_unit.sv
module pred_cond_unit
  import pcu_pkg::*;
#(
  parameter int OP_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        pred_code,
  input  logic [OP_W-1:0]   op_in,
  input  logic              reg_we_in,
  input  logic              flag_we,
  input  logic              c_in,
  input  logic              z_in,
  output logic              exec_en,
  output logic              opcode_ext,
  output logic [OP_W:0]     op_out,
  output logic              reg_we_out,
  output logic              flag_c,
  output logic              flag_z
);

  localparam int OUT_W = OP_W + 1;

  pred_t             code_s;
  logic [FLAG_N-1:0] flag_d;
  logic [FLAG_N-1:0] flag_q;
  logic              run_s;
  logic              ext_s;
  logic              flag_load;
  logic [OUT_W-1:0]  op_wide;

  assign code_s = pred_t'(pred_code);

  pcu_pred_eval u_eval (
    .code  (code_s),
    .cur_c (flag_q[FLAG_C_IDX]),
    .cur_z (flag_q[FLAG_Z_IDX]),
    .run   (run_s),
    .ext   (ext_s)
  );

  always_comb begin
    flag_d             = '0;
    flag_d[FLAG_C_IDX] = c_in;
    flag_d[FLAG_Z_IDX] = z_in;
    flag_load          = flag_we & run_s;
    op_wide            = {ext_s, op_in};
  end

  pcu_flag_bank #(.N(FLAG_N)) u_flags (
    .clk     (clk),
    .rst_n   (rst_n),
    .load_en (flag_load),
    .d       (flag_d),
    .q       (flag_q)
  );

  assign exec_en    = run_s;
  assign opcode_ext = ext_s;
  assign op_out     = op_wide;
  assign reg_we_out = reg_we_in & run_s;
  assign flag_c     = flag_q[FLAG_C_IDX];
  assign flag_z     = flag_q[FLAG_Z_IDX];

endmodule

// File: rtl/pred_cond_unit_chk.sv
module pred_cond_unit_chk #(
  parameter int OP_W = 5
) (
  input logic            clk,
  input logic            rst_n,
  input logic [2:0]      pred_code,
  input logic [OP_W-1:0] op_in,
  input logic            reg_we_in,
  input logic            flag_we,
  input logic            c_in,
  input logic            z_in,
  input logic            exec_en,
  input logic            opcode_ext,
  input logic [OP_W:0]   op_out,
  input logic            reg_we_out,
  input logic            flag_c,
  input logic            flag_z
);

  // R4
  p_ext_runs_r4: assert property (@(posedge clk) disable iff (!rst_n)
    opcode_ext |-> exec_en);

  // R5
  p_ext_only_reclaimed_r5: assert property (@(posedge clk) disable iff (!rst_n)
    opcode_ext |-> (pred_code == 3'b111));

  // R6
  p_op_widen_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (op_out[OP_W-1:0] == op_in) && (op_out[OP_W] == opcode_ext));

  // R7
  p_we_gated_r7: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we_out |-> (exec_en && reg_we_in));

  // R8
  p_flag_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_we && exec_en) |=> (flag_c == $past(c_in)) && (flag_z == $past(z_in)));

  // R9
  p_flag_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(flag_we && exec_en) |=> $stable(flag_c) && $stable(flag_z));

  // R3: the always-run code never blocks
  p_always_code_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (pred_code == 3'b011) |-> exec_en);

endmodule

bind pred_cond_unit pred_cond_unit_chk #(.OP_W(OP_W)) u_chk (.*);

// File: tb/pred_cond_unit_tb_top.sv
module pred_cond_unit_tb_top;

  localparam int OP_W = 5;

  logic            clk;
  logic            rst_n;
  logic [2:0]      pred_code;
  logic [OP_W-1:0] op_in;
  logic            reg_we_in;
  logic            flag_we;
  logic            c_in;
  logic            z_in;
  logic            exec_en;
  logic            opcode_ext;
  logic [OP_W:0]   op_out;
  logic            reg_we_out;
  logic            flag_c;
  logic            flag_z;

  int n_chk;
  int n_fail;
  bit done;

  // Per code: {run mask indexed by {C,Z}, ext}. Index 3 = C1 Z1, 0 = C0 Z0.
  localparam logic [4:0] VEC [8] = '{
    5'b1000_0,  // 000 C&Z
    5'b1100_0,  // 001 C
    5'b1010_0,  // 010 Z
    5'b1111_0,  // 011 always
    5'b0111_0,  // 100 !(C&Z)
    5'b0011_0,  // 101 !C
    5'b0101_0,  // 110 !Z
    5'b1111_1   // 111 reclaimed
  };

  pred_cond_unit #(.OP_W(OP_W)) dut_i (.*);

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic load_flags(input logic c, input logic z);
    @(negedge clk);
    pred_code = 3'b011; flag_we = 1'b1; c_in = c; z_in = z;
    @(negedge clk);
    flag_we = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=1 expected=0");
    finish_run();
  end

  initial begin
    n_chk = 0; n_fail = 0; done = 1'b0;
    rst_n = 1'b0; pred_code = 3'b011; op_in = '0; reg_we_in = 1'b0;
    flag_we = 1'b0; c_in = 1'b1; z_in = 1'b1;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 flag_c after reset", flag_c, 0);
    chk("R1 flag_z after reset", flag_z, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 R3 R4 R5 R6 R7: exhaustive sweep
    for (int f = 0; f < 4; f++) begin
      load_flags(f[1], f[0]);
      chk("R8 flag_c load", flag_c, f[1]);
      chk("R8 flag_z load", flag_z, f[0]);
      for (int k = 0; k < 8; k++) begin
        pred_code = k[2:0];
        op_in     = OP_W'(k * 3 + f);
        reg_we_in = 1'b1;
        #2;
        chk($sformatf("R3 exec code=%0d f=%0d", k, f), exec_en, VEC[k][1 + f]);
        chk($sformatf("R5 ext code=%0d", k), opcode_ext, VEC[k][0]);
        chk("R6 op_out", int'(op_out), int'({VEC[k][0], op_in}));
        chk("R7 reg_we_out", reg_we_out, VEC[k][1 + f]);
        reg_we_in = 1'b0;
        #1;
        chk("R7 reg_we_out idle", reg_we_out, 0);
        @(negedge clk);
      end
    end

    // R9: blocked instruction with flag_we is ignored
    load_flags(1'b1, 1'b1);
    @(negedge clk);
    pred_code = 3'b101; flag_we = 1'b1; c_in = 1'b0; z_in = 1'b0;
    #1 chk("R9 exec blocked", exec_en, 0);
    @(negedge clk);
    flag_we = 1'b0;
    chk("R9 flag_c held", flag_c, 1);
    chk("R9 flag_z held", flag_z, 1);

    // R10: same-cycle ALU flags do not affect the decision
    load_flags(1'b0, 1'b0);
    pred_code = 3'b010; flag_we = 1'b1; c_in = 1'b1; z_in = 1'b1;
    #2 chk("R10 exec uses stored Z", exec_en, 0);
    @(negedge clk);
    flag_we = 1'b0;
    chk("R10 flags unchanged", int'({flag_c, flag_z}), 0);

    // R8 R4: reclaimed code always runs and reloads flags
    pred_code = 3'b111; flag_we = 1'b1; c_in = 1'b1; z_in = 1'b0;
    #2 chk("R4 exec forced", exec_en, 1);
    @(negedge clk);
    flag_we = 1'b0;
    chk("R8 ext load flag_c", flag_c, 1);
    chk("R8 ext load flag_z", flag_z, 0);
    pred_code = 3'b010;
    #1 chk("R2 Z after ext load", exec_en, 0);
    pred_code = 3'b001;
    #1 chk("R2 C after ext load", exec_en, 1);

    // R1: asynchronous clear mid-run
    @(negedge clk);
    #1 rst_n = 1'b0;
    #1 chk("R1 async clear flag_c", flag_c, 0);
    chk("R1 async clear flag_z", flag_z, 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    finish_run();
  end

endmodule